// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital half of a 12-bit successive-approximation converter that sits behind a four-wire serial port. The wires are an active-low select, a serial clock, a command input and a result output. While select is low, the block ignores zeros on the command input. The first one it sees opens a command. The next three bits set three things in turn: single-ended or differential sampling, which channel is the positive one, and whether the result is sent once or twice.

After one idle sample clock, the block runs a binary search over twelve clocks. Each clock it presents a trial code to the external DAC model and reads back a one-bit comparator verdict. Each bit is sent on the serial output as soon as it is decided. If the command asked for the double format, the same word then follows least significant bit first, re-using the LSB that ended the first pass. When the transaction is over, further clocks have no effect until select goes high. Raising select at any point abandons the transaction.

The analog parts are not in this block. The block drives a two-bit channel-select word and the trial code, and it takes the comparator result as a plain input.

Top module: `sar_serial_ctl`

## Requirements
- R1: With select low, zeros on `din` before the first one are ignored. The first one sampled on a rising edge is the start bit.
- R2: The three rising edges after the start bit capture, in this order, the mode bit, the channel bit and the format bit. `mux_sel[1]` is the mode bit (1 = single-ended to ground, 0 = differential). `mux_sel[0]` is the channel bit (0 = channel 0 positive, 1 = channel 1 positive, with the other channel as the negative side in differential mode).
- R3: During the clock that decides bit i, `trial_code` holds the bits already decided above i, with bit i set and all lower bits zero. The first trial is the MSB alone. A bit stays 1 when `cmp_hi` is 1 on the rising edge that closes its trial; otherwise it is cleared.
- R4: Exactly one sample clock (rising edge 5, counting the start-bit edge as 1) separates the format bit from the MSB decision. `dout` is 0 through the command and sample clocks.
- R5: The bit decided on a rising edge appears on `dout` from the following falling edge. Bits are sent MSB first, on edges 6 to 17.
- R6: With format bit 1, the transaction ends on edge 17, and `dout` is 0 from the next clock on.
- R7: With format bit 0, edges 18 to 28 send D1 up to D11 of the same word. The transaction then ends, and `dout` is 0 afterwards.
- R8: `dout_oe` is low whenever `cs_n` is high and high whenever it is low.
- R9: Once a transaction has ended and select stays low, any further `din` ones start nothing. `trial_code` keeps holding the result word.
- R10: `cs_n` high at a rising edge aborts any transaction and returns the block to idle. The next transaction after select goes low again runs normally.
- R11: After reset, `trial_code` is 0, `mux_sel` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and idles |
| din | input | 1 | Serial command input |
| cmp_hi | input | 1 | Comparator verdict, 1 = trial code below the input |
| dout | output | 1 | Serial result output, updated on falling edge |
| dout_oe | output | 1 | Output enable for `dout` (low = high impedance) |
| mux_sel | output | 2 | {mode bit, channel bit} for the input multiplexer |
| trial_code | output | NBITS | Trial code to the DAC; holds the result when done |

## Verification
The bench places a comparator model on the DUT's own `mux_sel` and `trial_code` and sweeps the input across the whole range, including zero and above full scale. A wrong channel decode therefore shows up as a wrong result word, and a search that is off by one shows up at the extreme codes. Each transaction varies the number of leading zeros and alternates the format bit. A block that locked onto the wrong start edge would send a shifted word. A block that dropped the shared LSB or miscounted the replay would send a garbled second pass, or a bit after edge 17. Extra ones after completion and a select pulse in mid-conversion target a design that restarts when it should stay quiet, or that keeps state across an abort.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

   localparam int CMD_LEN = 3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CMD,
      PH_SAMP,
      PH_CONV,
      PH_REPLAY,
      PH_DONE
   } phase_t;

   typedef struct packed {
      logic single_end;
      logic odd_sel;
      logic msb_only;
   } cmd_t;

endpackage

// File: rtl/sar_ctl_seq.sv
module sar_ctl_seq
   import sar_ctl_pkg::*;
#(
   parameter int NBITS = 12,
   localparam int IW = $clog2(NBITS),
   localparam int CW = $clog2(CMD_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          din,
   output phase_t        phase,
   output logic [IW-1:0] idx,
   output cmd_t          cmd
);

   localparam logic [IW-1:0] IDX_TOP = IW'(NBITS - 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(CMD_LEN - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         cnt   <= '0;
         cmd   <= '0;
      end else if (cs_n) begin
         phase <= PH_IDLE;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (din) begin
                  phase <= PH_CMD;
                  cnt   <= '0;
               end
            end
            PH_CMD: begin
               case (cnt)
                  CW'(0):  cmd.single_end <= din;
                  CW'(1):  cmd.odd_sel    <= din;
                  default: cmd.msb_only   <= din;
               endcase
               cnt <= cnt + 1'b1;
               if (cnt == CNT_LAST) phase <= PH_SAMP;
            end
            PH_SAMP: begin
               phase <= PH_CONV;
               idx   <= IDX_TOP;
            end
            PH_CONV: begin
               if (idx == '0) begin
                  if (cmd.msb_only) begin
                     phase <= PH_DONE;
                  end else begin
                     phase <= PH_REPLAY;
                     idx   <= IW'(1);
                  end
               end else begin
                  idx <= idx - 1'b1;
               end
            end
            PH_REPLAY: begin
               if (idx == IDX_TOP) phase <= PH_DONE;
               else                idx   <= idx + 1'b1;
            end
            PH_DONE: phase <= PH_DONE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sar_ctl_reg.sv
module sar_ctl_reg
   import sar_ctl_pkg::*;
#(
   parameter int NBITS = 12,
   localparam int IW = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  phase_t           phase,
   input  logic [IW-1:0]    idx,
   input  logic             cmp_hi,
   output logic [NBITS-1:0] sar,
   output logic [NBITS-1:0] trial_code
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sar <= '0;
      end else if (!cs_n) begin
         if (phase == PH_SAMP)      sar      <= '0;
         else if (phase == PH_CONV) sar[idx] <= cmp_hi;
      end
   end

   always_comb begin
      trial_code = sar;
      if (phase == PH_CONV) trial_code[idx] = 1'b1;
   end

endmodule

// File: rtl/sar_ctl_dout.sv
module sar_ctl_dout
   import sar_ctl_pkg::*;
#(
   parameter int NBITS = 12,
   parameter bit DOUT_ON_FALL = 1'b1,
   localparam int IW = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  phase_t           phase,
   input  logic [IW-1:0]    idx,
   input  logic             cmp_hi,
   input  logic [NBITS-1:0] sar,
   output logic             dout
);

   logic shown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shown <= 1'b0;
      end else if (cs_n) begin
         shown <= 1'b0;
      end else begin
         case (phase)
            PH_CONV:   shown <= cmp_hi;
            PH_REPLAY: shown <= sar[idx];
            default:   shown <= 1'b0;
         endcase
      end
   end

   generate
      if (DOUT_ON_FALL) begin : g_fall
         logic dout_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) dout_q <= 1'b0;
            else        dout_q <= shown;
         end
         assign dout = dout_q;
      end else begin : g_rise
         assign dout = shown;
      end
   endgenerate

endmodule

// File: rtl/sar_serial_ctl.sv
module sar_serial_ctl
   import sar_ctl_pkg::*;
#(
   parameter int NBITS = 12,
   parameter bit DOUT_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             din,
   input  logic             cmp_hi,
   output logic             dout,
   output logic             dout_oe,
   output logic [1:0]       mux_sel,
   output logic [NBITS-1:0] trial_code
);

   localparam int IW = $clog2(NBITS);

   generate
      if (NBITS < 2 || NBITS > 32) begin : g_bad_width
         $error("sar_serial_ctl: NBITS must be within 2..32");
      end
   endgenerate

   phase_t          phase;
   logic [IW-1:0]   idx;
   cmd_t            cmd;
   logic [NBITS-1:0] sar;

   sar_ctl_seq #(.NBITS(NBITS)) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .din   (din),
      .phase (phase),
      .idx   (idx),
      .cmd   (cmd)
   );

   sar_ctl_reg #(.NBITS(NBITS)) reg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .phase      (phase),
      .idx        (idx),
      .cmp_hi     (cmp_hi),
      .sar        (sar),
      .trial_code (trial_code)
   );

   sar_ctl_dout #(.NBITS(NBITS), .DOUT_ON_FALL(DOUT_ON_FALL)) dout_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .phase  (phase),
      .idx    (idx),
      .cmp_hi (cmp_hi),
      .sar    (sar),
      .dout   (dout)
   );

   assign mux_sel = {cmd.single_end, cmd.odd_sel};
   assign dout_oe = ~cs_n;

endmodule

// File: rtl/sar_serial_ctl_chk.sv
module sar_serial_ctl_chk
   import sar_ctl_pkg::*;
#(
   parameter int NBITS = 12,
   localparam int IW = $clog2(NBITS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             din,
   input logic             cmp_hi,
   input logic [1:0]       mux_sel,
   input logic [NBITS-1:0] trial_code,
   input phase_t           phase,
   input logic [IW-1:0]    idx,
   input cmd_t             cmd,
   input logic [NBITS-1:0] sar
);

   localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

   // R10: select high forces idle on the next edge
   a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> phase == PH_IDLE);

   // R3: the first trial after the sample clock is the MSB alone
   a_r3_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SAMP && !cs_n) |=> trial_code == MSB_ONLY);

   // R3: the decided bit equals the comparator verdict of its trial
   a_r3_keep_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CONV && !cs_n) |=> sar[$past(idx)] == $past(cmp_hi));

   // R2: the bit after the start bit lands in the mode position
   a_r2_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && din && !cs_n) ##1 !cs_n |=> mux_sel[1] == $past(din));

   // R6: single-pass format finishes right after the LSB
   a_r6_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CONV && idx == '0 && cmd.msb_only && !cs_n) |=> phase == PH_DONE);

   // R9: a finished transaction holds its result
   a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE && !cs_n) |=> $stable(trial_code));

endmodule

bind sar_serial_ctl sar_serial_ctl_chk #(.NBITS(NBITS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .din        (din),
   .cmp_hi     (cmp_hi),
   .mux_sel    (mux_sel),
   .trial_code (trial_code),
   .phase      (phase),
   .idx        (idx),
   .cmd        (cmd),
   .sar        (sar)
);

// File: tb/sar_serial_ctl_tb.sv
module sar_serial_ctl_tb_top;

   localparam int NB = 12;
   localparam int FULL = 1 << NB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          din = 1'b0;
   logic          cmp_hi;
   logic          dout;
   logic          dout_oe;
   logic [1:0]    mux_sel;
   logic [NB-1:0] trial_code;

   int ch0 = 0;
   int ch1 = 0;
   int vin_eff;
   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sar_serial_ctl #(.NBITS(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .cmp_hi(cmp_hi),
      .dout(dout), .dout_oe(dout_oe), .mux_sel(mux_sel), .trial_code(trial_code)
   );

   // comparator model driven by the DUT's own channel selection
   always_comb begin
      int pos;
      int neg;
      pos = mux_sel[0] ? ch1 : ch0;
      neg = mux_sel[0] ? ch0 : ch1;
      vin_eff = mux_sel[1] ? pos : pos - neg;
   end
   assign cmp_hi = (int'(trial_code) < vin_eff);

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at posedge+6; drives din, returns dout after the next falling edge
   task automatic step(input logic d, output logic q);
      din = d;
      @(posedge clk);
      #6;
      q = dout;
   endtask

   function automatic int expect_code(input int v);
      if (v <= 0) return 0;
      if (v >= FULL) return FULL - 1;
      return v - 1;
   endfunction

   task automatic run_conv(input bit mode, input bit odd, input bit fmt,
                           input int c0, input int c1, input int lead);
      logic q;
      int zeros_bad;
      int exp, pos, neg;
      logic [NB-1:0] got, got2;
      ch0 = c0;
      ch1 = c1;
      pos = odd ? c1 : c0;
      neg = odd ? c0 : c1;
      exp = expect_code(mode ? pos : pos - neg);
      cs_n = 1'b0;
      zeros_bad = 0;
      for (int i = 0; i < lead; i++) begin
         step(1'b0, q);
         if (q !== 1'b0) zeros_bad++;
      end
      step(1'b1, q); if (q !== 1'b0) zeros_bad++;
      step(mode, q); if (q !== 1'b0) zeros_bad++;
      step(odd, q);  if (q !== 1'b0) zeros_bad++;
      step(fmt, q);  if (q !== 1'b0) zeros_bad++;
      step(1'b0, q); if (q !== 1'b0) zeros_bad++;
      check("R4 zero during command and sample clocks", zeros_bad, 0);
      check("R3 first trial is MSB only", int'(trial_code), 1 << (NB - 1));
      got = '0;
      for (int i = NB - 1; i >= 0; i--) begin
         step(1'b0, q);
         got[i] = q;
      end
      check(lead > 0 ? "R1/R5 MSB-first word after leading zeros"
                     : "R5 MSB-first word", int'(got), exp);
      if (!fmt) begin
         got2 = '0;
         got2[0] = got[0];
         for (int i = 1; i < NB; i++) begin
            step(1'b0, q);
            got2[i] = q;
         end
         check("R7 LSB-first replay", int'(got2), exp);
      end
      zeros_bad = 0;
      step(1'b0, q); if (q !== 1'b0) zeros_bad++;
      check(fmt ? "R6 output quiet after edge 17" : "R7 output quiet after edge 28",
            zeros_bad, 0);
      step(1'b1, q); if (q !== 1'b0) zeros_bad++;
      step(1'b0, q); if (q !== 1'b0) zeros_bad++;
      step(1'b1, q); if (q !== 1'b0) zeros_bad++;
      step(1'b1, q); if (q !== 1'b0) zeros_bad++;
      check("R9 no new conversion after completion", zeros_bad, 0);
      check("R9 result held on trial_code", int'(trial_code), exp);
      check("R2 mux_sel is {mode, channel}", int'(mux_sel), int'({mode, odd}));
      check("R8 dout_oe high while selected", int'(dout_oe), 1);
      cs_n = 1'b1;
      din = 1'b0;
      #1;
      check("R8 dout_oe low when deselected", int'(dout_oe), 0);
      @(posedge clk);
      #6;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : main
      logic q;
      repeat (3) @(posedge clk);
      #6;
      check("R11 reset trial_code", int'(trial_code), 0);
      check("R11 reset mux_sel", int'(mux_sel), 0);
      check("R11 reset dout", int'(dout), 0);
      check("R8 dout_oe low at reset with select high", int'(dout_oe), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #6;

      // R1: long run of leading zeros
      run_conv(1'b1, 1'b0, 1'b1, 1234, 0, 9);

      // single-ended channel 0 sweep, format alternating
      for (int v = 0; v <= FULL; v += 37)
         run_conv(1'b1, 1'b0, bit'((v / 37) % 2), v, (v * 7) % FULL, v % 3);
      run_conv(1'b1, 1'b0, 1'b0, FULL, 5, 0);
      run_conv(1'b1, 1'b0, 1'b1, FULL + 100, 5, 1);
      run_conv(1'b1, 1'b0, 1'b0, 1, 9, 0);

      // single-ended channel 1
      for (int v = 0; v <= FULL; v += 211)
         run_conv(1'b1, 1'b1, bit'((v / 211) % 2), FULL - 1 - (v % FULL), v, 1);

      // differential, both polarities, including negative difference
      for (int v = 0; v <= FULL; v += 257) begin
         run_conv(1'b0, 1'b0, 1'b0, v, 300, 0);
         run_conv(1'b0, 1'b1, 1'b1, 300, v, 2);
      end

      // R10: abort mid-conversion, then a normal transaction
      ch0 = 3000;
      ch1 = 0;
      cs_n = 1'b0;
      step(1'b1, q); step(1'b1, q); step(1'b0, q); step(1'b0, q); step(1'b0, q);
      for (int i = 0; i < 5; i++) step(1'b0, q);
      cs_n = 1'b1;
      #1;
      check("R8 dout_oe drops on mid-transaction deselect", int'(dout_oe), 0);
      @(posedge clk);
      #6;
      check("R10 output quiet after abort", int'(dout), 0);
      run_conv(1'b1, 1'b0, 1'b0, 2731, 0, 2);
      run_conv(1'b0, 1'b1, 1'b1, 100, 4000, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule